// File: doc/BRIEF.md
# Full-Search Block Motion Estimation SAD Engine

This block finds the motion vector of one 16x16 pixel macroblock inside a 33x33 pixel search window. Both pixel sets are written into local memories through two load ports, one pixel per cycle, each addressed by row and column. A start pulse then launches an exhaustive search over 256 candidate displacements. For each displacement the block forms the sum of absolute differences (SAD) between the macroblock and the displaced window region. It keeps the smallest SAD found so far, with its displacement.

The datapath has sixteen processing elements, one per macroblock column. Each cycle they handle one macroblock row: they read one pixel each from a column-banked search memory, form absolute differences, and feed a pipelined adder tree. An accumulator adds up the sixteen row sums of a candidate, and a comparator updates the running best. When the last candidate has been compared, a one-cycle done pulse presents the winning vector and its SAD. These outputs stay held until the next search finishes.

Top module: `me_sad_engine`

## Requirements
- R1: After synchronous reset, `done` is low and `best_sad`, `mv_dx` and `mv_dy` are all zero.
- R2: Macroblock pixel (row r, column c) is written at `mb_wr_row`=r, `mb_wr_col`=c. Window pixel (row a, column b), with a and b from 0 to 32, is written at `sa_wr_row`=a, `sa_wr_col`=b. All pixels are 8-bit unsigned.
- R3: The SAD of displacement (dx, dy) is the sum over r, c in 0..15 of |MB(r,c) - SA(r+dy+8, c+dx+8)|. So dx moves columns and dy moves rows.
- R4: The reported `best_sad` is the minimum SAD over all candidates, and (`mv_dx`, `mv_dy`) is a displacement that yields it.
- R5: Candidates run with dx as the outer loop and dy as the inner loop, each from -8 to +7. When two SADs are equal, the candidate evaluated later wins.
- R6: The running best starts at 65535 with vector (0,0). A candidate whose SAD is the largest possible value, 65280, still replaces that initial value.
- R7: `done` is high for exactly one cycle. It rises 4102 clock edges after the edge that samples an accepted `start`.
- R8: A `start` that arrives from its acceptance until `done` is ignored. Only one `done` occurs, at the normal time, with the correct result.
- R9: `best_sad`, `mv_dx` and `mv_dy` change only in the cycle `done` is high, and hold their value otherwise.
- R10: A `start` in the cycle right after `done` is accepted. Each search re-initialises its running best, so its result does not depend on earlier searches.
- R11: `mv_dx` and `mv_dy` are 5-bit two's complement values from -8 to +7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mb_we | input | 1 | Macroblock pixel write enable |
| mb_wr_row | input | 4 | Macroblock write row |
| mb_wr_col | input | 4 | Macroblock write column |
| mb_wr_data | input | 8 | Macroblock pixel value |
| sa_we | input | 1 | Search window pixel write enable |
| sa_wr_row | input | 6 | Search window write row (0..32) |
| sa_wr_col | input | 6 | Search window write column (0..32) |
| sa_wr_data | input | 8 | Search window pixel value |
| start | input | 1 | Pulse that launches a search when idle |
| done | output | 1 | One-cycle pulse when the result is valid |
| mv_dx | output | 5 | Winning horizontal displacement, signed |
| mv_dy | output | 5 | Winning vertical displacement, signed |
| best_sad | output | 16 | SAD of the winning displacement |

## Verification
The hardest case to reach is a start pulse that arrives after the candidate counter has already stopped, while the last candidates are still draining through the absolute-difference and adder-tree stages. A re-initialisation at that point would corrupt the answer without showing up anywhere else. The stimulus places one start pulse in the middle of a search and another two cycles before `done`. It then checks for a single done at the normal cycle with the model's answer. Ties are forced with uniform pictures: all-equal pixels give SAD 0 everywhere, and a zero macroblock against a saturated window gives the maximum SAD everywhere. Planted displacements at the corners of the range exercise the banked window memory at its column and row boundaries.

// File: rtl/me_pkg.sv
package me_pkg;
  localparam int PIX_W  = 8;
  localparam int MB_N   = 16;
  localparam int RANGE  = 8;
  localparam int SAD_W  = 16;
endpackage

// File: rtl/me_ctrl.sv
module me_ctrl #(
  parameter int MB_N  = me_pkg::MB_N,
  parameter int RANGE = me_pkg::RANGE,
  localparam int OFF_W = $clog2(2 * RANGE),
  localparam int ROW_W = $clog2(MB_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  output logic             busy,
  output logic [ROW_W-1:0] row,
  output logic [OFF_W-1:0] xi,
  output logic [OFF_W-1:0] yi,
  output logic             first,
  output logic             last,
  output logic             fin
);
  localparam int CNT_W = ROW_W + 2 * OFF_W;

  logic [CNT_W-1:0] cnt;

  // counter layout: row fastest, then dy index, then dx index (outer loop)
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (go) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (&cnt) busy <= 1'b0;
    end
  end

  assign row   = cnt[ROW_W-1:0];
  assign yi    = cnt[ROW_W +: OFF_W];
  assign xi    = cnt[ROW_W + OFF_W +: OFF_W];
  assign first = (row == '0);
  assign last  = &row;
  assign fin   = &cnt;

  // R7: the scan stops right after its final issue
  p_scan_stop_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && fin) |=> !busy);
  // R8: a launch only reaches an idle scanner
  p_go_idle_r8: assert property (@(posedge clk) disable iff (rst)
    go |-> !busy);
endmodule

// File: rtl/me_sa_banks.sv
module me_sa_banks #(
  parameter int PIX_W = me_pkg::PIX_W,
  parameter int MB_N  = me_pkg::MB_N,
  parameter int RANGE = me_pkg::RANGE,
  localparam int SA_N   = MB_N + 2 * RANGE + 1,
  localparam int IDX_W  = $clog2(SA_N),
  localparam int ROW_W  = $clog2(MB_N),
  localparam int OFF_W  = $clog2(2 * RANGE)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [IDX_W-1:0]        wr_row,
  input  logic [IDX_W-1:0]        wr_col,
  input  logic [PIX_W-1:0]        wr_data,
  input  logic [ROW_W-1:0]        rd_row,
  input  logic [OFF_W-1:0]        rd_yi,
  input  logic [OFF_W-1:0]        rd_xi,
  output logic [MB_N*PIX_W-1:0]   pix
);
  localparam int BANK_W = $clog2(MB_N);
  localparam int HI_W   = IDX_W - BANK_W;
  localparam int WORDS  = SA_N << HI_W;

  logic [IDX_W-1:0]       srow;
  logic [BANK_W-1:0]      xi_d;
  logic [MB_N*PIX_W-1:0]  q_all;

  assign srow = IDX_W'(rd_row) + IDX_W'(rd_yi);

  always_ff @(posedge clk) begin
    xi_d <= BANK_W'(rd_xi);
  end

  // one bank per column residue; consecutive columns never share a bank
  for (genvar b = 0; b < MB_N; b++) begin : g_bank
    logic [PIX_W-1:0]  mem [WORDS];
    logic [PIX_W-1:0]  q;
    logic [BANK_W-1:0] rel;
    logic [IDX_W-1:0]  col_b;

    assign rel   = BANK_W'(b) - BANK_W'(rd_xi);
    assign col_b = IDX_W'(rd_xi) + IDX_W'(rel);

    always_ff @(posedge clk) begin
      if (we && (wr_col[BANK_W-1:0] == BANK_W'(b)))
        mem[{wr_row, wr_col[IDX_W-1:BANK_W]}] <= wr_data;
      q <= mem[{srow, col_b[IDX_W-1:BANK_W]}];
    end

    assign q_all[b*PIX_W +: PIX_W] = q;
  end

  // rotate bank outputs back into processing-element order
  always_comb begin
    for (int c = 0; c < MB_N; c++) begin
      logic [BANK_W-1:0] sel;
      sel = BANK_W'(c) + xi_d;
      pix[c*PIX_W +: PIX_W] = q_all[sel*PIX_W +: PIX_W];
    end
  end

  // R2: window writes stay inside the 33x33 array
  p_load_bounds_r2: assert property (@(posedge clk) disable iff (rst)
    we |-> (wr_row < IDX_W'(SA_N)) && (wr_col < IDX_W'(SA_N)));
endmodule

// File: rtl/me_pe_array.sv
module me_pe_array #(
  parameter int PIX_W = me_pkg::PIX_W,
  parameter int MB_N  = me_pkg::MB_N,
  localparam int ROW_W = $clog2(MB_N)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [ROW_W-1:0]      wr_row,
  input  logic [ROW_W-1:0]      wr_col,
  input  logic [PIX_W-1:0]      wr_data,
  input  logic [ROW_W-1:0]      rd_row,
  input  logic [MB_N*PIX_W-1:0] sa_pix,
  output logic [MB_N*PIX_W-1:0] ad
);
  for (genvar c = 0; c < MB_N; c++) begin : g_pe
    logic [PIX_W-1:0] mem [MB_N];
    logic [PIX_W-1:0] m_q;
    logic [PIX_W-1:0] s;
    logic [PIX_W-1:0] ad_r;

    assign s = sa_pix[c*PIX_W +: PIX_W];

    always_ff @(posedge clk) begin
      if (we && (wr_col == ROW_W'(c)))
        mem[wr_row] <= wr_data;
      m_q <= mem[rd_row];
    end

    always_ff @(posedge clk) begin
      if (rst)           ad_r <= '0;
      else if (m_q >= s) ad_r <= m_q - s;
      else               ad_r <= s - m_q;
    end

    assign ad[c*PIX_W +: PIX_W] = ad_r;
  end
endmodule

// File: rtl/me_adder_tree.sv
module me_adder_tree #(
  parameter int IN_W  = me_pkg::PIX_W,
  parameter int N     = me_pkg::MB_N,
  parameter int OUT_W = me_pkg::SAD_W,
  localparam int LV   = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N*IN_W-1:0] din,
  output logic [OUT_W-1:0]  sum
);
  localparam logic [OUT_W-1:0] ROW_MAX = OUT_W'(N * ((1 << IN_W) - 1));

  for (genvar l = 0; l <= LV; l++) begin : g_lv
    localparam int CNT = N >> l;
    logic [OUT_W-1:0] s [CNT];
    if (l == 0) begin : g_in
      always_comb begin
        for (int i = 0; i < CNT; i++) s[i] = OUT_W'(din[i*IN_W +: IN_W]);
      end
    end else begin : g_add
      always_ff @(posedge clk) begin
        for (int i = 0; i < CNT; i++) begin
          if (rst) s[i] <= '0;
          else     s[i] <= g_lv[l-1].s[2*i] + g_lv[l-1].s[2*i+1];
        end
      end
    end
  end

  assign sum = g_lv[LV].s[0];

  // R4: a row sum never exceeds sixteen maximal differences
  p_row_bound_r4: assert property (@(posedge clk) disable iff (rst)
    sum <= ROW_MAX);
endmodule

// File: rtl/me_sad_engine.sv
module me_sad_engine #(
  parameter int PIX_W = me_pkg::PIX_W,
  parameter int MB_N  = me_pkg::MB_N,
  parameter int RANGE = me_pkg::RANGE,
  parameter int SAD_W = me_pkg::SAD_W,
  localparam int SA_N  = MB_N + 2 * RANGE + 1,
  localparam int IDX_W = $clog2(SA_N),
  localparam int ROW_W = $clog2(MB_N),
  localparam int OFF_W = $clog2(2 * RANGE),
  localparam int VEC_W = OFF_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mb_we,
  input  logic [ROW_W-1:0]        mb_wr_row,
  input  logic [ROW_W-1:0]        mb_wr_col,
  input  logic [PIX_W-1:0]        mb_wr_data,
  input  logic                    sa_we,
  input  logic [IDX_W-1:0]        sa_wr_row,
  input  logic [IDX_W-1:0]        sa_wr_col,
  input  logic [PIX_W-1:0]        sa_wr_data,
  input  logic                    start,
  output logic                    done,
  output logic signed [VEC_W-1:0] mv_dx,
  output logic signed [VEC_W-1:0] mv_dy,
  output logic [SAD_W-1:0]        best_sad
);
  localparam int LV    = $clog2(MB_N);
  localparam int LAT   = 2 + LV;
  localparam int TAG_W = 4 + 2 * OFF_W;
  localparam logic [SAD_W-1:0] SAD_MAX = SAD_W'(MB_N * MB_N * ((1 << PIX_W) - 1));

  logic                    run, accept, busy, first, last, fin;
  logic [ROW_W-1:0]        row;
  logic [OFF_W-1:0]        xi, yi;
  logic [MB_N*PIX_W-1:0]   sa_pix, ad;
  logic [SAD_W-1:0]        rs;
  logic [TAG_W-1:0]        tag_pipe [LAT];
  logic                    t_v, t_first, t_last, t_fin;
  logic [OFF_W-1:0]        t_xi, t_yi;
  logic [SAD_W-1:0]        acc, row_tot, cur_sad;
  logic [OFF_W-1:0]        cur_x, cur_y;
  logic                    take;

  assign accept = start & ~run;

  me_ctrl #(.MB_N(MB_N), .RANGE(RANGE)) ctrl_i (
    .clk(clk), .rst(rst), .go(accept), .busy(busy), .row(row),
    .xi(xi), .yi(yi), .first(first), .last(last), .fin(fin)
  );

  me_sa_banks #(.PIX_W(PIX_W), .MB_N(MB_N), .RANGE(RANGE)) sa_i (
    .clk(clk), .rst(rst), .we(sa_we), .wr_row(sa_wr_row), .wr_col(sa_wr_col),
    .wr_data(sa_wr_data), .rd_row(row), .rd_yi(yi), .rd_xi(xi), .pix(sa_pix)
  );

  me_pe_array #(.PIX_W(PIX_W), .MB_N(MB_N)) pe_i (
    .clk(clk), .rst(rst), .we(mb_we), .wr_row(mb_wr_row), .wr_col(mb_wr_col),
    .wr_data(mb_wr_data), .rd_row(row), .sa_pix(sa_pix), .ad(ad)
  );

  me_adder_tree #(.IN_W(PIX_W), .N(MB_N), .OUT_W(SAD_W)) tree_i (
    .clk(clk), .rst(rst), .din(ad), .sum(rs)
  );

  // tag line matches memory read, PE stage and tree levels
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < LAT; j++) tag_pipe[j] <= '0;
    end else begin
      tag_pipe[0] <= {busy, first, last, fin, xi, yi};
      for (int j = 1; j < LAT; j++) tag_pipe[j] <= tag_pipe[j-1];
    end
  end

  assign t_v     = tag_pipe[LAT-1][TAG_W-1];
  assign t_first = tag_pipe[LAT-1][TAG_W-2];
  assign t_last  = tag_pipe[LAT-1][TAG_W-3];
  assign t_fin   = tag_pipe[LAT-1][TAG_W-4];
  assign t_xi    = tag_pipe[LAT-1][2*OFF_W-1:OFF_W];
  assign t_yi    = tag_pipe[LAT-1][OFF_W-1:0];

  assign row_tot = t_first ? rs : acc + rs;
  assign take    = (row_tot <= cur_sad);

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      done     <= 1'b0;
      acc      <= '0;
      cur_sad  <= '1;
      cur_x    <= OFF_W'(RANGE);
      cur_y    <= OFF_W'(RANGE);
      best_sad <= '0;
      mv_dx    <= '0;
      mv_dy    <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        run     <= 1'b1;
        cur_sad <= '1;
        cur_x   <= OFF_W'(RANGE);
        cur_y   <= OFF_W'(RANGE);
      end
      if (t_v) begin
        acc <= row_tot;
        if (t_last && take) begin
          cur_sad <= row_tot;
          cur_x   <= t_xi;
          cur_y   <= t_yi;
        end
        if (t_last && t_fin) begin
          done     <= 1'b1;
          run      <= 1'b0;
          best_sad <= take ? row_tot : cur_sad;
          mv_dx    <= VEC_W'(take ? t_xi : cur_x) - VEC_W'(RANGE);
          mv_dy    <= VEC_W'(take ? t_yi : cur_y) - VEC_W'(RANGE);
        end
      end
    end
  end

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9: results move only together with done
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(best_sad) && $stable(mv_dx) && $stable(mv_dy)));
  // R4: the running best never grows inside a search
  p_best_mono_r4: assert property (@(posedge clk) disable iff (rst)
    !accept |=> (cur_sad <= $past(cur_sad)));
  // R6: a finished candidate sum fits the largest possible SAD
  p_sad_max_r6: assert property (@(posedge clk) disable iff (rst)
    (t_v && t_last) |-> (row_tot <= SAD_MAX));
  // R8: a start seen during a search leaves the search running
  p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (start && run && !(t_v && t_last && t_fin)) |=> run);
endmodule

// File: tb/me_sad_engine_tb_top.sv
`timescale 1ns/1ps
module me_sad_engine_tb_top;
  localparam int EXP_LAT = 4102;
  localparam int NV = 7;
  // stimulus vectors: mode, seed, planted dx, planted dy
  localparam int V_MODE [NV] = '{0, 1, 0, 0, 2, 3, 4};
  localparam int V_SEED [NV] = '{11, 11, 29, 47, 0, 0, 83};
  localparam int V_PDX  [NV] = '{3, 3, -8, 7, 0, 0, 0};
  localparam int V_PDY  [NV] = '{-5, -5, -8, -8, 0, 0, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mb_we = 1'b0, sa_we = 1'b0, start = 1'b0;
  logic [3:0] mb_wr_row = '0, mb_wr_col = '0;
  logic [5:0] sa_wr_row = '0, sa_wr_col = '0;
  logic [7:0] mb_wr_data = '0, sa_wr_data = '0;
  logic done;
  logic signed [4:0] mv_dx, mv_dy;
  logic [15:0] best_sad;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int sa_m [33][33];
  int mb_m [16][16];
  int ex, ey, es;
  int lat, lat2, ndone;
  int ux, uy, us;

  always #2.5 clk = ~clk;

  me_sad_engine dut_i (
    .clk(clk), .rst(rst),
    .mb_we(mb_we), .mb_wr_row(mb_wr_row), .mb_wr_col(mb_wr_col), .mb_wr_data(mb_wr_data),
    .sa_we(sa_we), .sa_wr_row(sa_wr_row), .sa_wr_col(sa_wr_col), .sa_wr_data(sa_wr_data),
    .start(start), .done(done), .mv_dx(mv_dx), .mv_dy(mv_dy), .best_sad(best_sad)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic fill(input int mode, input int seed, input int pdx, input int pdy);
    int unsigned st;
    st = seed;
    for (int r = 0; r < 33; r++)
      for (int c = 0; c < 33; c++) begin
        st = st * 1103515245 + 12345;
        sa_m[r][c] = (mode == 2) ? 255 : (mode == 3) ? 77 : int'((st >> 16) & 255);
      end
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) begin
        st = st * 1103515245 + 12345;
        case (mode)
          2: mb_m[r][c] = 0;
          3: mb_m[r][c] = 77;
          4: mb_m[r][c] = int'((st >> 16) & 255);
          default: mb_m[r][c] = sa_m[r + pdy + 8][c + pdx + 8];
        endcase
        if (mode == 1 && ((r == 5 && c == 9) || (r == 12 && c == 2)))
          mb_m[r][c] = mb_m[r][c] ^ 64;
      end
  endtask

  task automatic model(output int bx, output int by, output int bs);
    bs = 65535; bx = 0; by = 0;
    for (int x = -8; x < 8; x++)
      for (int y = -8; y < 8; y++) begin
        int s;
        s = 0;
        for (int r = 0; r < 16; r++)
          for (int c = 0; c < 16; c++) begin
            int d;
            d = mb_m[r][c] - sa_m[r + y + 8][c + x + 8];
            s += (d < 0) ? -d : d;
          end
        if (s <= bs) begin bs = s; bx = x; by = y; end
      end
  endtask

  task automatic load_all();
    for (int r = 0; r < 33; r++)
      for (int c = 0; c < 33; c++) begin
        @(negedge clk);
        sa_we = 1'b1; sa_wr_row = 6'(r); sa_wr_col = 6'(c); sa_wr_data = 8'(sa_m[r][c]);
      end
    @(negedge clk); sa_we = 1'b0;
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        mb_we = 1'b1; mb_wr_row = 4'(r); mb_wr_col = 4'(c); mb_wr_data = 8'(mb_m[r][c]);
      end
    @(negedge clk); mb_we = 1'b0;
  endtask

  // n counts negedges after the edge that samples the launching start
  task automatic run_search(input int e1, input int e2, input int upto,
                            output int l1, output int l2, output int nd);
    int n;
    l1 = -1; l2 = -1; nd = 0; n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (n < upto) begin
      @(negedge clk);
      n++;
      start = (n == e1 || n == e2);
      if (done) begin
        nd++;
        if (l1 < 0) l1 = n; else l2 = n;
        if (upto == 0) break;
      end
      if (l1 >= 0 && upto == 0) break;
      if (upto == 0 && n > 6000) break;
    end
    if (upto == 0) begin
      while (l1 < 0 && n < 6000) begin
        @(negedge clk); n++;
        if (done) begin nd++; l1 = n; end
      end
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(best_sad == 16'd0, "R1 sad", int'(best_sad), 0);
    chk(mv_dx == 5'sd0, "R1 dx", int'(mv_dx), 0);
    chk(mv_dy == 5'sd0, "R1 dy", int'(mv_dy), 0);

    for (int v = 0; v < NV; v++) begin
      fill(V_MODE[v], V_SEED[v], V_PDX[v], V_PDY[v]);
      model(ex, ey, es);
      load_all();
      run_search(-1, -1, 0, lat, lat2, ndone);
      chk(lat == EXP_LAT, "R7 latency", lat, EXP_LAT);
      chk(int'(best_sad) == es, "R2 R4 sad", int'(best_sad), es);
      chk(int'(mv_dx) == ex, "R3 R11 dx", int'(mv_dx), ex);
      chk(int'(mv_dy) == ey, "R3 R11 dy", int'(mv_dy), ey);
      if (V_MODE[v] == 0) begin
        chk(int'(mv_dx) == V_PDX[v], "R3 planted dx", int'(mv_dx), V_PDX[v]);
        chk(int'(mv_dy) == V_PDY[v], "R3 planted dy", int'(mv_dy), V_PDY[v]);
      end
      if (V_MODE[v] == 1)  // follows a zero-SAD run: R10 reinit
        chk(best_sad != 16'd0, "R10 reinit sad", int'(best_sad), es);
      if (V_MODE[v] == 2) begin
        chk(best_sad == 16'd65280, "R6 max sad", int'(best_sad), 65280);
        chk(mv_dx == 5'sd7 && mv_dy == 5'sd7, "R5 R6 last tie", int'(mv_dx), 7);
      end
      if (V_MODE[v] == 3) begin
        chk(best_sad == 16'd0, "R5 zero sad", int'(best_sad), 0);
        chk(mv_dx == 5'sd7 && mv_dy == 5'sd7, "R5 last tie", int'(mv_dy), 7);
      end
      us = int'(best_sad); ux = int'(mv_dx); uy = int'(mv_dy);
      repeat (30) @(negedge clk);
      chk(!done && int'(best_sad) == us && int'(mv_dx) == ux && int'(mv_dy) == uy,
          "R9 hold", int'(best_sad), us);
    end

    // R8: starts in mid-search and during the pipeline tail are ignored
    fill(0, 91, -3, 6);
    model(ex, ey, es);
    load_all();
    run_search(2000, EXP_LAT - 2, EXP_LAT + 300, lat, lat2, ndone);
    chk(ndone == 1, "R8 single done", ndone, 1);
    chk(lat == EXP_LAT, "R8 done time", lat, EXP_LAT);
    chk(int'(best_sad) == es && int'(mv_dx) == ex && int'(mv_dy) == ey,
        "R8 result", int'(best_sad), es);

    // R10: start in the cycle that shows done launches a new search
    run_search(EXP_LAT, -1, 2 * EXP_LAT + 100, lat, lat2, ndone);
    chk(ndone == 2, "R10 two dones", ndone, 2);
    chk(lat2 == 2 * EXP_LAT + 1, "R10 second done time", lat2, 2 * EXP_LAT + 1);
    chk(int'(best_sad) == es && int'(mv_dx) == ex && int'(mv_dy) == ey,
        "R10 result", int'(best_sad), es);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule